// File: doc/BRIEF.md
# Audio DAC Zero-Sample Detector

This block watches the left and right sample streams on their way into a stereo DAC and notices when a channel has gone silent. A channel is silent after a long, unbroken run of exactly-zero samples. Each channel has its own saturating run counter, and a counter moves only on cycles that carry a sample strobe. A channel's result counts only while that channel feeds the analog output summer.

The two per-channel results are mapped onto two active-high zero-flag outputs. A 2-bit mode selector picks the mapping: off, each flag following its own channel, both flags requiring both channels, or both flags following either channel. The flags typically drive external mute circuitry. A separate request output asks the programmable-gain stage to mute when auto-mute is enabled and the audible output is silent.

Top module: `dac_zero_watch`

## Requirements
- R1: A channel is zero-detected once RUN_LEN (default 1024) strobed zero samples have arrived in a row. Its result appears in the cycle after the clock edge that registers the last of those samples, and not after RUN_LEN-1 of them.
- R2: A nonzero sample taken on a strobe clears that channel's run. Its detection is gone in the cycle after that edge.
- R3: The run counter saturates, so a channel stays detected through any number of zero samples beyond RUN_LEN, with no wrap.
- R4: Samples on cycles without the strobe are ignored, whether zero or nonzero, and leave the run unchanged.
- R5: With `flag_mode` = 2'b00, both flags are held at 0.
- R6: With `flag_mode` = 2'b01, `zflag_left` shows the gated left result and `zflag_right` shows the gated right result.
- R7: With `flag_mode` = 2'b10, both flags are 1 only when both gated results are set.
- R8: With `flag_mode` = 2'b11, both flags are 1 when either gated result is set.
- R9: A channel whose summer enable is 0 is treated as not zero in the flags and in the mute request. Its counter keeps running.
- R10: `pga_mute_req` is 1 exactly when `automute_en` is 1, at least one channel feeds the summer, and every feeding channel is zero-detected. It does not depend on `flag_mode`.
- R11: A synchronous active-high `rst` clears both runs, so all three outputs read 0 in the cycle after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample strobe; a sample is taken on edges where this is 1 |
| smp_left | input | SAMPLE_W | Left signed sample word |
| smp_right | input | SAMPLE_W | Right signed sample word |
| flag_mode | input | 2 | Flag mapping: 00 off, 01 per channel, 10 both, 11 either |
| mix_en_left | input | 1 | Left channel feeds the output summer |
| mix_en_right | input | 1 | Right channel feeds the output summer |
| automute_en | input | 1 | Allow silence to request a gain-stage mute |
| zflag_left | output | 1 | Left zero flag, active high |
| zflag_right | output | 1 | Right zero flag, active high |
| pga_mute_req | output | 1 | Mute request to the gain stage |

## Verification
The assertions assume the mode, enable and sample inputs are steady around each rising edge, and they make no assumption about how often the strobe comes. The stimulus therefore changes every input just after a falling edge and holds it for a whole cycle. Strobed and unstrobed cycles are mixed, and nonzero values are placed on unstrobed cycles to test R4. Every mode and enable combination is applied only while the counters hold known values, so each flag and mute check has a single correct answer.

// File: rtl/zdet_pkg.sv
`timescale 1ns/1ps
package zdet_pkg;

    typedef enum logic [1:0] {
        ZF_OFF   = 2'b00,
        ZF_SPLIT = 2'b01,
        ZF_BOTH  = 2'b10,
        ZF_ANY   = 2'b11
    } zf_mode_e;

    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_L   = 0;
    localparam int unsigned CH_R   = 1;

endpackage

// File: rtl/zdet_run_counter.sv
`timescale 1ns/1ps
module zdet_run_counter #(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RUN_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_en,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                run_done
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_en) begin
            if (sample != '0) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_done = (st_q.cnt == CNT_MAX);

    p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_MAX);

    p_nonzero_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (sample_en && sample != '0) |=> (st_q.cnt == '0));

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(st_q.cnt));

    p_zero_advances_r1: assert property (@(posedge clk) disable iff (rst)
        (sample_en && sample == '0 && st_q.cnt != CNT_MAX) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/zdet_flag_map.sv
`timescale 1ns/1ps
module zdet_flag_map
    import zdet_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       live_l,
    input  logic       live_r,
    output logic       flag_l,
    output logic       flag_r
);
    zf_mode_e mode_e;

    always_comb begin
        mode_e = zf_mode_e'(mode);
        flag_l = 1'b0;
        flag_r = 1'b0;
        unique case (mode_e)
            ZF_OFF: begin
                flag_l = 1'b0;
                flag_r = 1'b0;
            end
            ZF_SPLIT: begin
                flag_l = live_l;
                flag_r = live_r;
            end
            ZF_BOTH: begin
                flag_l = live_l & live_r;
                flag_r = live_l & live_r;
            end
            ZF_ANY: begin
                flag_l = live_l | live_r;
                flag_r = live_l | live_r;
            end
            default: begin
                flag_l = 1'b0;
                flag_r = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (mode == 2'b00) begin
            a_off_r5: assert (!flag_l && !flag_r);
        end
    end

endmodule

// File: rtl/dac_zero_watch.sv
`timescale 1ns/1ps
module dac_zero_watch
    import zdet_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RUN_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_en,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic [1:0]          flag_mode,
    input  logic                mix_en_left,
    input  logic                mix_en_right,
    input  logic                automute_en,
    output logic                zflag_left,
    output logic                zflag_right,
    output logic                pga_mute_req
);
    logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_vec;
    logic [NUM_CH-1:0]               mix_vec;
    logic [NUM_CH-1:0]               done_vec;
    logic [NUM_CH-1:0]               live_vec;

    assign smp_vec[CH_L] = smp_left;
    assign smp_vec[CH_R] = smp_right;
    assign mix_vec[CH_L] = mix_en_left;
    assign mix_vec[CH_R] = mix_en_right;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        zdet_run_counter #(
            .SAMPLE_W (SAMPLE_W),
            .RUN_LEN  (RUN_LEN)
        ) u_run (
            .clk       (clk),
            .rst       (rst),
            .sample_en (sample_en),
            .sample    (smp_vec[ch]),
            .run_done  (done_vec[ch])
        );
        assign live_vec[ch] = done_vec[ch] & mix_vec[ch];
    end

    zdet_flag_map u_map (
        .mode   (flag_mode),
        .live_l (live_vec[CH_L]),
        .live_r (live_vec[CH_R]),
        .flag_l (zflag_left),
        .flag_r (zflag_right)
    );

    // Mute only when every channel feeding the summer is silent.
    always_comb begin
        pga_mute_req = automute_en && (mix_vec != '0) && ((done_vec & mix_vec) == mix_vec);
    end

    p_gate_split_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_mode == 2'b01 && !mix_en_left) |-> !zflag_left);

    p_both_equal_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_mode == 2'b10 || flag_mode == 2'b11) |-> (zflag_left == zflag_right));

    p_mute_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
        pga_mute_req |-> (automute_en && (mix_en_left || mix_en_right)));

    p_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!zflag_left && !zflag_right && !pga_mute_req));

endmodule

// File: tb/dac_zero_watch_test.sv
`timescale 1ns/1ps
module dac_zero_watch_test;
    localparam int SW  = 24;
    localparam int RUN = 1024;

    logic          clk = 1'b0;
    logic          rst;
    logic          sample_en;
    logic [SW-1:0] smp_left, smp_right;
    logic [1:0]    flag_mode;
    logic          mix_en_left, mix_en_right, automute_en;
    logic          zflag_left, zflag_right, pga_mute_req;

    int checks = 0;
    int errors = 0;
    int m_l = 0;
    int m_r = 0;

    always #2.5 clk = ~clk;

    dac_zero_watch #(.SAMPLE_W(SW), .RUN_LEN(RUN)) uut (
        .clk(clk), .rst(rst), .sample_en(sample_en),
        .smp_left(smp_left), .smp_right(smp_right), .flag_mode(flag_mode),
        .mix_en_left(mix_en_left), .mix_en_right(mix_en_right),
        .automute_en(automute_en), .zflag_left(zflag_left),
        .zflag_right(zflag_right), .pga_mute_req(pga_mute_req)
    );

    // Behavioural reference: run lengths as plain integers.
    always @(posedge clk) begin
        if (rst) begin
            m_l <= 0;
            m_r <= 0;
        end else if (sample_en) begin
            m_l <= (smp_left  != 0) ? 0 : ((m_l < RUN) ? m_l + 1 : m_l);
            m_r <= (smp_right != 0) ? 0 : ((m_r < RUN) ? m_r + 1 : m_r);
        end
    end

    task automatic expect_bit(input string tag, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b (runs %0d/%0d mode %b)",
                     tag, what, got, exp, m_l, m_r, flag_mode);
        end
    endtask

    task automatic compare_model(input string tag);
        logic gl, gr, fl, fr, mu;
        gl = (m_l >= RUN) && mix_en_left;
        gr = (m_r >= RUN) && mix_en_right;
        case (flag_mode)
            2'b00:   begin fl = 1'b0;    fr = 1'b0;    end
            2'b01:   begin fl = gl;      fr = gr;      end
            2'b10:   begin fl = gl & gr; fr = gl & gr; end
            default: begin fl = gl | gr; fr = gl | gr; end
        endcase
        mu = automute_en && (mix_en_left || mix_en_right)
             && (!mix_en_left || m_l >= RUN) && (!mix_en_right || m_r >= RUN);
        expect_bit(tag, "zflag_left", zflag_left, fl);
        expect_bit(tag, "zflag_right", zflag_right, fr);
        expect_bit(tag, "pga_mute_req", pga_mute_req, mu);
    endtask

    // Drive one cycle just after a falling edge, compare, and move to the next falling edge.
    task automatic step(input string tag, input logic en, input int l, input int r);
        sample_en = en;
        smp_left  = SW'(l);
        smp_right = SW'(r);
        #1;
        compare_model(tag);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle(input string tag);
        sample_en = 1'b0;
        #1;
        compare_model(tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; sample_en = 1'b0; smp_left = '0; smp_right = '0;
        flag_mode = 2'b11; mix_en_left = 1'b1; mix_en_right = 1'b1; automute_en = 1'b1;
        @(negedge clk);
        step("R11", 1'b1, 0, 0);
        step("R11", 1'b1, 0, 0);
        expect_bit("R11", "zflag_left", zflag_left, 1'b0);
        expect_bit("R11", "pga_mute_req", pga_mute_req, 1'b0);
        rst = 1'b0;
        flag_mode = 2'b01;

        // R1 and R4: left counts zeros, right stays busy; unstrobed junk between.
        for (int i = 0; i < RUN - 1; i++) begin
            if (i % 100 == 50) step("R4", 1'b0, 7, 0);
            step("R1", 1'b1, 0, 5 + i);
        end
        settle("R1");
        expect_bit("R1", "zflag_left after RUN-1 zeros", zflag_left, 1'b0);
        step("R1", 1'b1, 0, 3);
        settle("R1");
        expect_bit("R1", "zflag_left after RUN zeros", zflag_left, 1'b1);
        expect_bit("R6", "zflag_right busy", zflag_right, 1'b0);

        // R4: unstrobed nonzero must not break the run.
        step("R4", 1'b0, 9, 9);
        settle("R4");
        expect_bit("R4", "zflag_left kept", zflag_left, 1'b1);

        // R3: well past the counter width.
        for (int i = 0; i < RUN + 100; i++) step("R3", 1'b1, 0, 1);
        settle("R3");
        expect_bit("R3", "zflag_left saturated", zflag_left, 1'b1);

        // R10 and R9: right busy, so mute only once right leaves the summer.
        expect_bit("R10", "pga_mute_req right busy", pga_mute_req, 1'b0);
        mix_en_right = 1'b0;
        settle("R10");
        expect_bit("R10", "pga_mute_req right out", pga_mute_req, 1'b1);
        mix_en_left = 1'b0;
        settle("R9");
        expect_bit("R9", "zflag_left gated", zflag_left, 1'b0);
        expect_bit("R10", "pga_mute_req none feeding", pga_mute_req, 1'b0);
        mix_en_left = 1'b1; mix_en_right = 1'b1;

        // R2: a strobed nonzero breaks the run.
        step("R2", 1'b1, -1, 0);
        settle("R2");
        expect_bit("R2", "zflag_left cleared", zflag_left, 1'b0);

        // Both channels silent, with the right one gated meanwhile (R9 counter keeps running).
        mix_en_right = 1'b0;
        for (int i = 0; i < RUN; i++) step("R9", 1'b1, 0, 0);
        mix_en_right = 1'b1;
        settle("R9");
        expect_bit("R9", "zflag_right after ungate", zflag_right, 1'b1);

        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 4; e++) begin
                flag_mode = 2'(m);
                mix_en_left = e[0];
                mix_en_right = e[1];
                settle(m == 0 ? "R5" : m == 1 ? "R6" : m == 2 ? "R7" : "R8");
                step("R9", 1'b0, 0, 0);
            end
        end

        // Left busy, right silent: both-mode low, either-mode high.
        mix_en_left = 1'b1; mix_en_right = 1'b1;
        step("R2", 1'b1, 4, 0);
        flag_mode = 2'b10;
        settle("R7");
        expect_bit("R7", "zflag_left both", zflag_left, 1'b0);
        flag_mode = 2'b11;
        settle("R8");
        expect_bit("R8", "zflag_left either", zflag_left, 1'b1);
        expect_bit("R8", "zflag_right either", zflag_right, 1'b1);
        flag_mode = 2'b00;
        settle("R5");
        expect_bit("R5", "zflag_right off", zflag_right, 1'b0);
        automute_en = 1'b0;
        mix_en_left = 1'b0;
        settle("R10");
        expect_bit("R10", "pga_mute_req disabled", pga_mute_req, 1'b0);
        automute_en = 1'b1;
        settle("R10");
        expect_bit("R10", "pga_mute_req enabled", pga_mute_req, 1'b1);

        // R11: reset in the middle of a detected run.
        flag_mode = 2'b11;
        rst = 1'b1;
        step("R11", 1'b1, 0, 0);
        rst = 1'b0;
        settle("R11");
        expect_bit("R11", "zflag_right after reset", zflag_right, 1'b0);
        expect_bit("R11", "pga_mute_req after reset", pga_mute_req, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule